// File: doc/BRIEF.md
# Split Instruction/Data Scratchpad Controller

The block sits next to a processor core and gives it two tightly coupled on-chip memories with a fixed one-cycle read latency and no wait states. The fetch side is read-only. It returns a 64-bit word that holds two consecutive 32-bit instructions. Its storage is filled only through a separate initialization write port, which is typically driven by a loader at boot.

The data side serves 32-bit loads and stores from the processor, with per-byte enables for narrow stores. A second, independent port lets fabric logic read and write the same data storage. This port is how the processor and accelerators exchange buffers.

Each side compares the request address against a base address that can be changed at run time. A request inside the window is claimed and flagged non-cacheable. Any other request is flagged for forwarding to the next memory level.

Top module: `spm_split_ctrl`

## Requirements
- R1: A fetch request is claimed (`if_claim_o` high, `if_fwd_o` low) in the same cycle when `if_addr_i[31:11]` equals `if_base_i[31:11]`. The window is 2 KB by default, which is `IMEM_WORDS`*8 bytes. Any other fetch request raises `if_fwd_o` and leaves `if_claim_o` low. With no request, both outputs are low. A new base value takes effect immediately.
- R2: One clock edge after a claimed fetch, `if_rvalid_o` is high and `if_rdata_o` holds the 64-bit word at word index `if_addr_i[10:3]`. Bits 31:0 hold the instruction at the lower address. In cycles after an unclaimed or absent fetch, `if_rvalid_o` is low.
- R3: Instruction storage is written only through `init_we_i`/`init_idx_i`/`init_wdata_i`. A fetch issued in the same cycle as an init write to the same word returns the old contents. A fetch issued in any later cycle returns the new contents.
- R4: A data request is claimed when `d_addr_i[31:10]` equals `d_base_i[31:10]`. The window is 1 KB by default, which is `DMEM_WORDS`*4 bytes. Any other data request raises `d_fwd_o`, and its write does not alter any stored word.
- R5: A claimed data read, `d_we_i` low, gives `d_rvalid_o` high one edge later, with the word at index `d_addr_i[9:2]` on `d_rdata_o`. A claimed write produces no `d_rvalid_o`.
- R6: On a processor write, `d_be_i[k]` enables byte k, which is bits 8k+7:8k. Bytes whose enable is low keep their previous value.
- R7: The fabric port reaches the same data storage by word index `fab_idx_i`, with the same byte-enable meaning. A fabric read gives `fab_rvalid_o` and `fab_rdata_o` one edge later. Writes from either port are visible to reads from the other port in the following cycle.
- R8: When the processor and the fabric write the same word in the same cycle, only the processor's enabled bytes are written and the fabric write to that word is dropped entirely. When they write different words in the same cycle, both writes take effect.
- R9: Every claimed request on either side raises the matching non-cacheable flag (`if_nocache_o` or `d_nocache_o`) in the cycle the request is claimed.
- R10: While `rst_ni` is low, all three read-valid outputs and all read-data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_base_i | input | 32 | Fetch window base address |
| if_req_i | input | 1 | Fetch request |
| if_addr_i | input | 32 | Fetch byte address |
| if_claim_o | output | 1 | Fetch claimed by this block |
| if_fwd_o | output | 1 | Fetch passed to next level |
| if_nocache_o | output | 1 | Fetch access is non-cacheable |
| if_rvalid_o | output | 1 | Fetch data valid |
| if_rdata_o | output | 64 | Two instructions |
| init_we_i | input | 1 | Instruction init write enable |
| init_idx_i | input | IIDX_W | Instruction init word index |
| init_wdata_i | input | 64 | Instruction init data |
| d_base_i | input | 32 | Data window base address |
| d_req_i | input | 1 | Data request |
| d_we_i | input | 1 | Data write (1) or read (0) |
| d_be_i | input | 4 | Data byte enables |
| d_addr_i | input | 32 | Data byte address |
| d_wdata_i | input | 32 | Data write bus |
| d_claim_o | output | 1 | Data request claimed |
| d_fwd_o | output | 1 | Data request passed to next level |
| d_nocache_o | output | 1 | Data access is non-cacheable |
| d_rvalid_o | output | 1 | Data read valid |
| d_rdata_o | output | 32 | Data read bus |
| fab_en_i | input | 1 | Fabric port access |
| fab_we_i | input | 1 | Fabric write (1) or read (0) |
| fab_be_i | input | 4 | Fabric byte enables |
| fab_idx_i | input | DIDX_W | Fabric word index |
| fab_wdata_i | input | 32 | Fabric write data |
| fab_rvalid_o | output | 1 | Fabric read valid |
| fab_rdata_o | output | 32 | Fabric read data |

## Verification
The bench goes after the window edges. It fetches just above the top of each window and below its base, and it moves the base at run time. A decoder that compared too few address bits would claim aliased addresses and corrupt word 0 through an out-of-window store. The bench reads back after partial-byte writes, which catches a design that ignored the byte enables or shifted them to the wrong lanes. It exercises same-cycle init-and-fetch and same-cycle processor-and-fabric writes, both to the same word and to different words. A design that gave priority to the fabric, merged the two ports' bytes, or returned write-first data would show the wrong word in the following read.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned FETCH_W = 64;
  localparam int unsigned LANES   = DATA_W / 8;
endpackage

// File: rtl/spm_decode.sv
module spm_decode #(
  parameter int unsigned LSB = 11
) (
  input  logic                      req_i,
  input  logic [spm_pkg::ADDR_W-1:0] addr_i,
  input  logic [spm_pkg::ADDR_W-1:0] base_i,
  output logic                      claim_o,
  output logic                      fwd_o
);
  logic hit;
  assign hit     = (addr_i[spm_pkg::ADDR_W-1:LSB] == base_i[spm_pkg::ADDR_W-1:LSB]);
  assign claim_o = req_i & hit;
  assign fwd_o   = req_i & ~hit;

  logic unused_low;
  assign unused_low = ^{addr_i[LSB-1:0], base_i[LSB-1:0]};
endmodule

// File: rtl/spm_imem.sv
module spm_imem #(
  parameter int unsigned WORDS = 256,
  parameter int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        rd_en_i,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [spm_pkg::FETCH_W-1:0] rdata_o,
  input  logic                        init_we_i,
  input  logic [IDX_W-1:0]            init_idx_i,
  input  logic [spm_pkg::FETCH_W-1:0] init_wdata_i
);
  logic [spm_pkg::FETCH_W-1:0] mem_q [WORDS];

  // only the init path writes; fetch is read-only
  always_ff @(posedge clk_i) begin
    if (init_we_i) mem_q[init_idx_i] <= init_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[rd_idx_i];
  end
endmodule

// File: rtl/spm_dmem.sv
module spm_dmem #(
  parameter int unsigned WORDS = 256,
  parameter int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        c_en_i,
  input  logic                        c_we_i,
  input  logic [spm_pkg::LANES-1:0]   c_be_i,
  input  logic [IDX_W-1:0]            c_idx_i,
  input  logic [spm_pkg::DATA_W-1:0]  c_wdata_i,
  output logic [spm_pkg::DATA_W-1:0]  c_rdata_o,
  input  logic                        f_en_i,
  input  logic                        f_we_i,
  input  logic [spm_pkg::LANES-1:0]   f_be_i,
  input  logic [IDX_W-1:0]            f_idx_i,
  input  logic [spm_pkg::DATA_W-1:0]  f_wdata_i,
  output logic [spm_pkg::DATA_W-1:0]  f_rdata_o
);
  logic c_wr, f_wr, f_wr_ok;
  assign c_wr    = c_en_i & c_we_i;
  assign f_wr    = f_en_i & f_we_i;
  // processor owns a contended word outright
  assign f_wr_ok = f_wr & ~(c_wr & (c_idx_i == f_idx_i));

  for (genvar b = 0; b < spm_pkg::LANES; b++) begin : g_lane
    logic [7:0] lane_q [WORDS];

    always_ff @(posedge clk_i) begin
      if (f_wr_ok && f_be_i[b]) lane_q[f_idx_i] <= f_wdata_i[b*8 +: 8];
      if (c_wr && c_be_i[b])    lane_q[c_idx_i] <= c_wdata_i[b*8 +: 8];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_rdata_o[b*8 +: 8] <= '0;
        f_rdata_o[b*8 +: 8] <= '0;
      end else begin
        if (c_en_i && !c_we_i) c_rdata_o[b*8 +: 8] <= lane_q[c_idx_i];
        if (f_en_i && !f_we_i) f_rdata_o[b*8 +: 8] <= lane_q[f_idx_i];
      end
    end
  end
endmodule

// File: rtl/spm_split_ctrl.sv
module spm_split_ctrl
  import spm_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 256,
  parameter int unsigned DMEM_WORDS = 256,
  parameter int unsigned IIDX_W     = $clog2(IMEM_WORDS),
  parameter int unsigned DIDX_W     = $clog2(DMEM_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  if_base_i,
  input  logic               if_req_i,
  input  logic [ADDR_W-1:0]  if_addr_i,
  output logic               if_claim_o,
  output logic               if_fwd_o,
  output logic               if_nocache_o,
  output logic               if_rvalid_o,
  output logic [FETCH_W-1:0] if_rdata_o,
  input  logic               init_we_i,
  input  logic [IIDX_W-1:0]  init_idx_i,
  input  logic [FETCH_W-1:0] init_wdata_i,
  input  logic [ADDR_W-1:0]  d_base_i,
  input  logic               d_req_i,
  input  logic               d_we_i,
  input  logic [LANES-1:0]   d_be_i,
  input  logic [ADDR_W-1:0]  d_addr_i,
  input  logic [DATA_W-1:0]  d_wdata_i,
  output logic               d_claim_o,
  output logic               d_fwd_o,
  output logic               d_nocache_o,
  output logic               d_rvalid_o,
  output logic [DATA_W-1:0]  d_rdata_o,
  input  logic               fab_en_i,
  input  logic               fab_we_i,
  input  logic [LANES-1:0]   fab_be_i,
  input  logic [DIDX_W-1:0]  fab_idx_i,
  input  logic [DATA_W-1:0]  fab_wdata_i,
  output logic               fab_rvalid_o,
  output logic [DATA_W-1:0]  fab_rdata_o
);
  localparam int unsigned I_LSB = IIDX_W + $clog2(FETCH_W / 8);
  localparam int unsigned D_LSB = DIDX_W + $clog2(DATA_W / 8);

  logic [IIDX_W-1:0] i_idx;
  logic [DIDX_W-1:0] d_idx;
  assign i_idx = if_addr_i[I_LSB-1 -: IIDX_W];
  assign d_idx = d_addr_i[D_LSB-1 -: DIDX_W];

  spm_decode #(.LSB(I_LSB)) i_idec (
    .req_i(if_req_i), .addr_i(if_addr_i), .base_i(if_base_i),
    .claim_o(if_claim_o), .fwd_o(if_fwd_o)
  );

  spm_decode #(.LSB(D_LSB)) i_ddec (
    .req_i(d_req_i), .addr_i(d_addr_i), .base_i(d_base_i),
    .claim_o(d_claim_o), .fwd_o(d_fwd_o)
  );

  // scratchpad space is never cacheable
  assign if_nocache_o = if_claim_o;
  assign d_nocache_o  = d_claim_o;

  spm_imem #(.WORDS(IMEM_WORDS), .IDX_W(IIDX_W)) i_imem (
    .clk_i, .rst_ni,
    .rd_en_i(if_claim_o), .rd_idx_i(i_idx), .rdata_o(if_rdata_o),
    .init_we_i, .init_idx_i, .init_wdata_i
  );

  spm_dmem #(.WORDS(DMEM_WORDS), .IDX_W(DIDX_W)) i_dmem (
    .clk_i, .rst_ni,
    .c_en_i(d_claim_o), .c_we_i(d_we_i), .c_be_i(d_be_i), .c_idx_i(d_idx),
    .c_wdata_i(d_wdata_i), .c_rdata_o(d_rdata_o),
    .f_en_i(fab_en_i), .f_we_i(fab_we_i), .f_be_i(fab_be_i), .f_idx_i(fab_idx_i),
    .f_wdata_i(fab_wdata_i), .f_rdata_o(fab_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_rvalid_o  <= 1'b0;
      d_rvalid_o   <= 1'b0;
      fab_rvalid_o <= 1'b0;
    end else begin
      if_rvalid_o  <= if_claim_o;
      d_rvalid_o   <= d_claim_o & ~d_we_i;
      fab_rvalid_o <= fab_en_i & ~fab_we_i;
    end
  end
endmodule

// File: rtl/spm_split_chk.sv
module spm_split_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic if_req_i,
  input logic if_claim_o,
  input logic if_fwd_o,
  input logic if_nocache_o,
  input logic if_rvalid_o,
  input logic d_req_i,
  input logic d_we_i,
  input logic d_claim_o,
  input logic d_fwd_o,
  input logic d_rvalid_o,
  input logic fab_en_i,
  input logic fab_we_i,
  input logic fab_rvalid_o
);
  assert_iclaim_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_req_i |-> (if_claim_o != if_fwd_o));
  assert_iclaim_noreq_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_req_i |-> !(if_claim_o || if_fwd_o));
  assert_ifetch_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_claim_o |=> if_rvalid_o);
  assert_ifetch_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_claim_o |=> !if_rvalid_o);
  assert_dclaim_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_req_i |-> (d_claim_o != d_fwd_o));
  assert_dread_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_claim_o && !d_we_i) |=> d_rvalid_o);
  assert_dwrite_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!d_claim_o || d_we_i) |=> !d_rvalid_o);
  assert_fab_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fab_en_i && !fab_we_i) |=> fab_rvalid_o);
  assert_fetch_nocache_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_rvalid_o |-> $past(if_nocache_o));
endmodule

bind spm_split_ctrl spm_split_chk i_spm_split_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .if_req_i(if_req_i), .if_claim_o(if_claim_o), .if_fwd_o(if_fwd_o),
  .if_nocache_o(if_nocache_o), .if_rvalid_o(if_rvalid_o),
  .d_req_i(d_req_i), .d_we_i(d_we_i), .d_claim_o(d_claim_o), .d_fwd_o(d_fwd_o),
  .d_rvalid_o(d_rvalid_o),
  .fab_en_i(fab_en_i), .fab_we_i(fab_we_i), .fab_rvalid_o(fab_rvalid_o)
);

// File: tb/test_spm_split_ctrl.sv
module test_spm_split_ctrl;
  localparam int ILSB = 11;
  localparam int DLSB = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] if_base_i = 32'h0001_0000;
  logic        if_req_i = 1'b0;
  logic [31:0] if_addr_i = '0;
  logic        if_claim_o, if_fwd_o, if_nocache_o, if_rvalid_o;
  logic [63:0] if_rdata_o;
  logic        init_we_i = 1'b0;
  logic [7:0]  init_idx_i = '0;
  logic [63:0] init_wdata_i = '0;
  logic [31:0] d_base_i = 32'h0002_0000;
  logic        d_req_i = 1'b0;
  logic        d_we_i = 1'b0;
  logic [3:0]  d_be_i = '0;
  logic [31:0] d_addr_i = '0;
  logic [31:0] d_wdata_i = '0;
  logic        d_claim_o, d_fwd_o, d_nocache_o, d_rvalid_o;
  logic [31:0] d_rdata_o;
  logic        fab_en_i = 1'b0;
  logic        fab_we_i = 1'b0;
  logic [3:0]  fab_be_i = '0;
  logic [7:0]  fab_idx_i = '0;
  logic [31:0] fab_wdata_i = '0;
  logic        fab_rvalid_o;
  logic [31:0] fab_rdata_o;

  always #5 clk_i = ~clk_i;

  spm_split_ctrl i_spm_split_ctrl (.*);

  typedef struct { logic [63:0] data; string tag; } exp_t;
  exp_t iq[$], dq[$], fq[$];
  logic [63:0] imodel [256];
  logic [31:0] dmodel [256];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  string tag = "R2";

  task automatic chk(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp_v);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w, input logic [3:0] be);
    logic [31:0] r = old_w;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = new_w[k*8 +: 8];
    return r;
  endfunction

  // scoreboard monitor
  initial forever begin
    exp_t e;
    @(negedge clk_i);
    if (rst_ni) begin
      if (if_rvalid_o) begin
        if (iq.size() == 0) chk(0, "R2 unexpected fetch valid", if_rdata_o, '0);
        else begin e = iq.pop_front(); chk(if_rdata_o === e.data, e.tag, if_rdata_o, e.data); end
      end else if (iq.size() != 0) begin
        e = iq.pop_front(); chk(0, {e.tag, " missing fetch valid"}, '0, e.data);
      end
      if (d_rvalid_o) begin
        if (dq.size() == 0) chk(0, "R5 unexpected data valid", {32'h0, d_rdata_o}, '0);
        else begin e = dq.pop_front(); chk({32'h0, d_rdata_o} === e.data, e.tag, {32'h0, d_rdata_o}, e.data); end
      end else if (dq.size() != 0) begin
        e = dq.pop_front(); chk(0, {e.tag, " missing data valid"}, '0, e.data);
      end
      if (fab_rvalid_o) begin
        if (fq.size() == 0) chk(0, "R7 unexpected fabric valid", {32'h0, fab_rdata_o}, '0);
        else begin e = fq.pop_front(); chk({32'h0, fab_rdata_o} === e.data, e.tag, {32'h0, fab_rdata_o}, e.data); end
      end else if (fq.size() != 0) begin
        e = fq.pop_front(); chk(0, {e.tag, " missing fabric valid"}, '0, e.data);
      end
    end
  end

  // driver: check decode, push expectations, update model, advance one cycle
  task automatic step();
    bit ic, dc, collide;
    logic [7:0] di;
    #1;
    ic = ((if_addr_i >> ILSB) == (if_base_i >> ILSB));
    if (if_req_i) begin
      chk(if_claim_o === ic && if_fwd_o === !ic, "R1 fetch decode", {62'h0, if_claim_o, if_fwd_o}, {62'h0, ic, !ic});
      if (ic) begin
        chk(if_nocache_o === 1'b1, "R9 fetch nocache", {63'h0, if_nocache_o}, 64'h1);
        iq.push_back('{imodel[if_addr_i[ILSB-1:3]], tag});
      end
    end else begin
      ic = 0;
      chk(!if_claim_o && !if_fwd_o, "R1 idle decode", {62'h0, if_claim_o, if_fwd_o}, '0);
    end
    if (init_we_i) imodel[init_idx_i] = init_wdata_i;

    dc = d_req_i && ((d_addr_i >> DLSB) == (d_base_i >> DLSB));
    di = d_addr_i[DLSB-1:2];
    if (d_req_i) begin
      chk(d_claim_o === dc && d_fwd_o === !dc, "R4 data decode", {62'h0, d_claim_o, d_fwd_o}, {62'h0, dc, !dc});
      if (dc) chk(d_nocache_o === 1'b1, "R9 data nocache", {63'h0, d_nocache_o}, 64'h1);
      if (dc && !d_we_i) dq.push_back('{{32'h0, dmodel[di]}, tag});
    end
    if (fab_en_i && !fab_we_i) fq.push_back('{{32'h0, dmodel[fab_idx_i]}, tag});
    collide = dc && d_we_i && fab_en_i && fab_we_i && (fab_idx_i == di);
    if (fab_en_i && fab_we_i && !collide) dmodel[fab_idx_i] = merge(dmodel[fab_idx_i], fab_wdata_i, fab_be_i);
    if (dc && d_we_i) dmodel[di] = merge(dmodel[di], d_wdata_i, d_be_i);

    @(negedge clk_i);
    if_req_i = 0; init_we_i = 0; d_req_i = 0; d_we_i = 0; fab_en_i = 0; fab_we_i = 0;
  endtask

  task automatic fetch(input logic [31:0] a);
    if_req_i = 1; if_addr_i = a; step();
  endtask
  task automatic init_w(input logic [7:0] i, input logic [63:0] v);
    init_we_i = 1; init_idx_i = i; init_wdata_i = v; step();
  endtask
  task automatic dwrite(input logic [31:0] a, input logic [3:0] be, input logic [31:0] v);
    d_req_i = 1; d_we_i = 1; d_addr_i = a; d_be_i = be; d_wdata_i = v; step();
  endtask
  task automatic dread(input logic [31:0] a);
    d_req_i = 1; d_we_i = 0; d_addr_i = a; step();
  endtask
  task automatic fwrite(input logic [7:0] i, input logic [3:0] be, input logic [31:0] v);
    fab_en_i = 1; fab_we_i = 1; fab_idx_i = i; fab_be_i = be; fab_wdata_i = v; step();
  endtask
  task automatic fread(input logic [7:0] i);
    fab_en_i = 1; fab_we_i = 0; fab_idx_i = i; step();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!if_rvalid_o && !d_rvalid_o && !fab_rvalid_o, "R10 valids in reset",
        {61'h0, if_rvalid_o, d_rvalid_o, fab_rvalid_o}, '0);
    chk(if_rdata_o === '0 && d_rdata_o === '0 && fab_rdata_o === '0, "R10 rdata in reset",
        if_rdata_o | {32'h0, d_rdata_o | fab_rdata_o}, '0);
    rst_ni = 1;
    @(negedge clk_i);

    // R3 fill via init, R2 fetch back
    for (int i = 0; i < 8; i++) init_w(8'(i), {32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i)});
    init_w(8'd255, 64'hFEED_0000_0000_BEEF);
    tag = "R2";
    for (int i = 0; i < 8; i++) fetch(32'h0001_0000 + 32'(i * 8));
    fetch(32'h0001_07F8);

    // R3 same-cycle init and fetch returns old, later returns new
    tag = "R3";
    if_req_i = 1; if_addr_i = 32'h0001_0018;
    init_we_i = 1; init_idx_i = 8'd3; init_wdata_i = 64'h1234_5678_9ABC_DEF0;
    step();
    fetch(32'h0001_0018);

    // R1 out of window above, below, then moved base
    tag = "R1";
    fetch(32'h0001_0800);
    fetch(32'h0000_FFF8);
    step();
    if_base_i = 32'h0004_0000;
    fetch(32'h0004_0010);
    fetch(32'h0001_0010);
    if_base_i = 32'h0001_0000;

    // R5 data writes and reads
    tag = "R5";
    for (int i = 0; i < 8; i++) dwrite(32'h0002_0000 + 32'(i * 4), 4'hF, 32'hD000_0000 + 32'(i * 17));
    for (int i = 0; i < 8; i++) dread(32'h0002_0000 + 32'(i * 4));

    // R4 out-of-window store must not alias word 0
    tag = "R4";
    dwrite(32'h0002_0400, 4'hF, 32'hBAD0_BAD0);
    dwrite(32'h0001_FFFC, 4'hF, 32'hBAD1_BAD1);
    dread(32'h0002_0000);
    dread(32'h0002_0400);

    // R6 byte enables
    tag = "R6";
    dwrite(32'h0002_0008, 4'b0001, 32'h1111_11AA);
    dread(32'h0002_0008);
    dwrite(32'h0002_0008, 4'b0110, 32'h22BB_CC22);
    dread(32'h0002_0008);
    dwrite(32'h0002_0008, 4'b1000, 32'hEE33_3333);
    dread(32'h0002_0008);

    // R7 fabric port sharing
    tag = "R7";
    fwrite(8'd5, 4'hF, 32'hFAB0_0005);
    dread(32'h0002_0014);
    dwrite(32'h0002_0018, 4'hF, 32'hC0DE_0006);
    fread(8'd6);
    fwrite(8'd7, 4'b1100, 32'h7777_0000);
    fread(8'd7);

    // R8 same-word collision: processor only
    tag = "R8";
    d_req_i = 1; d_we_i = 1; d_addr_i = 32'h0002_0010; d_be_i = 4'hF; d_wdata_i = 32'hC1C1_C1C1;
    fab_en_i = 1; fab_we_i = 1; fab_idx_i = 8'd4; fab_be_i = 4'hF; fab_wdata_i = 32'hF1F1_F1F1;
    step();
    dread(32'h0002_0010);
    d_req_i = 1; d_we_i = 1; d_addr_i = 32'h0002_0010; d_be_i = 4'b0001; d_wdata_i = 32'h0000_0055;
    fab_en_i = 1; fab_we_i = 1; fab_idx_i = 8'd4; fab_be_i = 4'hF; fab_wdata_i = 32'hF2F2_F2F2;
    step();
    fread(8'd4);
    // different words: both land
    d_req_i = 1; d_we_i = 1; d_addr_i = 32'h0002_0000; d_be_i = 4'hF; d_wdata_i = 32'hC3C3_C3C3;
    fab_en_i = 1; fab_we_i = 1; fab_idx_i = 8'd1; fab_be_i = 4'hF; fab_wdata_i = 32'hF3F3_F3F3;
    step();
    dread(32'h0002_0000);
    fread(8'd1);
    // simultaneous processor read and fabric read of different words
    d_req_i = 1; d_we_i = 0; d_addr_i = 32'h0002_001C;
    fab_en_i = 1; fab_we_i = 0; fab_idx_i = 8'd2;
    step();

    repeat (3) @(negedge clk_i);
    chk(iq.size() == 0 && dq.size() == 0 && fq.size() == 0, "R2 pending responses",
        64'(iq.size() + dq.size() + fq.size()), '0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule